// File: doc/BRIEF.md
# Programmable Even-Ratio Clock Output

This block derives an external clock from the bus clock. Software writes an 8-bit control register that holds a run bit and a 3-bit ratio field. When the run bit is set and the ratio field holds a value N from 1 to 7, the output toggles every N bus cycles. The result is a square wave with a period of 2×N bus cycles and equal high and low phases. When the run bit is set but the ratio is zero, the output enable is asserted and the pin is driven low. When the run bit is clear, the output enable is released and the data output stays low.

A new register value does not reach the running divider straight away. The divider takes a new configuration only at the end of a low phase, or at once while it is idle. A phase that has started therefore always runs to its full length, and a change of ratio or a shutdown never produces a shortened pulse. The output and its enable both come directly from flops.

Top module: `clkout_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, rd_data, clk_oe and clk_out are all 0.
- R2: A register write stores bit 4 as the run bit and bits 2:0 as the ratio N. The stored value reads back in the same positions from the cycle after the write.
- R3: Register bits 7:5 and bit 3 always read as 0, and writing 1s to them changes nothing else.
- R4: With the run bit set and N from 1 to 7, the output has a period of 2×N bus cycles, measured between successive rising edges.
- R5: Each high phase and each low phase lasts exactly N bus cycles, which gives a 50% duty cycle.
- R6: With the run bit set and N = 0, clk_oe is 1 and clk_out stays 0.
- R7: With the run bit clear, once any started period has completed, clk_oe is 0 and clk_out is 0.
- R8: A change of configuration written while the divider is running takes effect only at the end of a low phase. The high and low phase already in progress keep the old ratio.
- R9: From the idle state, a write that sets the run bit with ratio N raises clk_oe one cycle after the write edge. The first rising edge of clk_out comes N+1 cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| clk_out | output | 1 | Divided clock output |
| clk_oe | output | 1 | Output-enable for the clock pin |

## Verification
The in-line assertions check, on every cycle, the properties of the divider's state. The output is low whenever the enable is low or the ratio is zero. The phase counter never passes the active ratio. The active configuration cannot change during a high phase. Every rising edge follows a complete low count. The bench scenarios are needed for what only shows up over many cycles: the actual period and duty cycle for each ratio, the delay from a write to the first edge, and the old ratio finishing its phases after a change.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    localparam int REG_W   = 8;
    localparam int SEL_W   = 3;
    localparam int RUN_POS = 4;

    typedef struct packed {
        logic             run;
        logic [SEL_W-1:0] ratio;
    } ck_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } ck_phase_t;

    function automatic logic cfg_toggles(input ck_cfg_t c);
        return c.run && (c.ratio != '0);
    endfunction

    function automatic logic [REG_W-1:0] cfg_to_word(input ck_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[RUN_POS]     = c.run;
        w[SEL_W-1:0]   = c.ratio;
        return w;
    endfunction

    function automatic ck_cfg_t word_to_cfg(input logic [REG_W-1:0] w);
        ck_cfg_t c;
        c.run   = w[RUN_POS];
        c.ratio = w[SEL_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/clkout_cfg_reg.sv
module clkout_cfg_reg
    import clkout_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output ck_cfg_t          cfg
);

    ck_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= word_to_cfg(wr_data);
        end
    end

    assign cfg     = cfg_q;
    assign rd_data = cfg_to_word(cfg_q);

    // R1: reset clears the stored configuration
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cfg_q == '0));

    // R2: a write lands in the configuration fields
    p_write_store_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cfg_q.run == $past(wr_data[RUN_POS]))
               && (cfg_q.ratio == $past(wr_data[SEL_W-1:0])));

endmodule

// File: rtl/clkout_phase_gen.sv
module clkout_phase_gen
    import clkout_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ck_cfg_t cfg,
    output logic    clk_out,
    output logic    clk_oe
);

    ck_cfg_t          act_q;
    ck_phase_t        phase_q;
    logic [SEL_W-1:0] cnt_q;
    logic             out_q;

    logic             at_end;
    assign at_end = (cnt_q == act_q.ratio);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= '0;
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            out_q   <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    act_q <= cfg;
                    out_q <= 1'b0;
                    if (cfg_toggles(cfg)) begin
                        phase_q <= PH_LOW;
                        cnt_q   <= SEL_W'(1);
                    end else begin
                        cnt_q   <= '0;
                    end
                end
                PH_LOW: begin
                    if (at_end) begin
                        act_q <= cfg;
                        if (cfg_toggles(cfg)) begin
                            phase_q <= PH_HIGH;
                            out_q   <= 1'b1;
                            cnt_q   <= SEL_W'(1);
                        end else begin
                            phase_q <= PH_IDLE;
                            out_q   <= 1'b0;
                            cnt_q   <= '0;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (at_end) begin
                        phase_q <= PH_LOW;
                        out_q   <= 1'b0;
                        cnt_q   <= SEL_W'(1);
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                    out_q   <= 1'b0;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign clk_out = out_q;
    assign clk_oe  = act_q.run;

    // R7: pin data is low whenever the enable is released
    p_off_low_r7: assert property (@(posedge clk) disable iff (rst)
        !clk_oe |-> !clk_out);

    // R6: a zero ratio never drives the pin high
    p_zero_ratio_low_r6: assert property (@(posedge clk) disable iff (rst)
        (act_q.ratio == '0) |-> !out_q);

    // R5: the phase counter stays within 1..N while toggling
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE) |-> ((cnt_q != '0) && (cnt_q <= act_q.ratio)));

    // R8: the active configuration is frozen during a high phase
    p_hold_in_high_r8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HIGH) |=> (act_q == $past(act_q)));

    // R4: a rising edge only follows a full low count
    p_rise_full_low_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(out_q) |-> ($past(cnt_q) == $past(act_q.ratio)));

endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
    import clkout_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             clk_out,
    output logic             clk_oe
);

    ck_cfg_t cfg;

    clkout_cfg_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .cfg     (cfg)
    );

    clkout_phase_gen u_gen (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .clk_out (clk_out),
        .clk_oe  (clk_oe)
    );

    // R3: reserved register bits never read as 1
    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en) |-> (rd_data[7:5] == 3'b000) && (rd_data[3] == 1'b0));

endmodule

// File: tb/sim_clkout_gen.sv
module sim_clkout_gen;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       clk_out;
    logic       clk_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10ns clk = ~clk;

    clkout_gen u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .clk_out (clk_out),
        .clk_oe  (clk_oe)
    );

    // write data (reserved bits set), expected readback, expected period
    localparam logic [7:0] VEC_WR  [7] = '{8'hF9, 8'hFA, 8'hFB, 8'hFC, 8'hFD, 8'hFE, 8'hFF};
    localparam logic [7:0] VEC_RD  [7] = '{8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17};
    localparam int         VEC_PER [7] = '{2, 4, 6, 8, 10, 12, 14};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_level(input logic lvl, output int n);
        n = 0;
        while (clk_out !== lvl && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic sync_rise();
        int n;
        wait_level(1'b0, n);
        wait_level(1'b1, n);
        wait_level(1'b0, n);
        wait_level(1'b1, n);
    endtask

    initial begin
        #3ms;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int hi, lo, n, k;
        bit stayed;
        rst = 1'b1; wr_en = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
        check(clk_oe == 1'b0,   "R1 clk_oe", clk_oe, 0);
        check(clk_out == 1'b0,  "R1 clk_out", clk_out, 0);
        rst = 1'b0;
        @(negedge clk);
        check(rd_data == 8'h00 && !clk_oe && !clk_out, "R1 after release", rd_data, 0);

        // R9: first edge timing from idle with N=3
        wr_en = 1'b1; wr_data = 8'h13;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        k = 0;
        do begin
            @(negedge clk);
            k++;
            if (k == 1) check(clk_oe == 1'b1, "R9 oe one cycle after write", clk_oe, 1);
        end while (!clk_out && k < 50);
        check(k == 4, "R9 first rise delay", k, 4);

        // R4 R5 R2 R3: table walk over every ratio
        for (int i = 0; i < 7; i++) begin
            write_reg(VEC_WR[i]);
            check(rd_data == VEC_RD[i], "R2 R3 readback", rd_data, VEC_RD[i]);
            sync_rise();
            wait_level(1'b0, hi);
            wait_level(1'b1, lo);
            check(hi == VEC_PER[i] / 2, "R5 high phase", hi, VEC_PER[i] / 2);
            check(lo == VEC_PER[i] / 2, "R5 low phase", lo, VEC_PER[i] / 2);
            check(hi + lo == VEC_PER[i], "R4 period", hi + lo, VEC_PER[i]);
        end

        // R8: ratio change mid high phase keeps the old ratio until a low ends
        write_reg(8'h17);
        sync_rise();
        write_reg(8'h11);
        wait_level(1'b0, n);
        hi = n + 1;
        wait_level(1'b1, lo);
        check(hi == 7, "R8 old high kept", hi, 7);
        check(lo == 7, "R8 old low kept", lo, 7);
        wait_level(1'b0, hi);
        wait_level(1'b1, lo);
        check(hi == 1 && lo == 1, "R8 new ratio applied", hi + lo, 2);

        // R3: reserved bits ignored with run clear
        write_reg(8'hEF);
        check(rd_data == 8'h07, "R3 reserved ignored", rd_data, 7);

        // R7: disabled output goes quiet
        repeat (20) @(negedge clk);
        check(clk_oe == 1'b0, "R7 oe released", clk_oe, 0);
        stayed = 1;
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            if (clk_out !== 1'b0 || clk_oe !== 1'b0) stayed = 0;
        end
        check(stayed, "R7 output held low", stayed, 1);

        // R6: run set with zero ratio
        write_reg(8'h10);
        @(negedge clk);
        stayed = 1;
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            if (clk_out !== 1'b0 || clk_oe !== 1'b1) stayed = 0;
        end
        check(stayed, "R6 zero ratio low with oe", stayed, 1);
        check(rd_data == 8'h10, "R2 zero ratio readback", rd_data, 16);

        // R7: shutdown from running ratio 3 completes then goes quiet
        write_reg(8'h13);
        sync_rise();
        write_reg(8'h03);
        repeat (12) @(negedge clk);
        check(!clk_oe && !clk_out, "R7 shutdown from running", {clk_oe, clk_out}, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule